// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block decides which peripheral signal drives each of 32 port pins, arranged as four ports of eight pins. A configuration word holds peripheral enables, a per-pin skip mask and the SPI wire mode. It is captured into registers on a load strobe. A combinational walk then visits the pins from the lowest to the highest and hands each enabled signal, in a fixed priority order, the next pin that is free and not skipped. Pins left over after the walk become general-purpose I/O.

Two UART0 signals have fixed pins and never enter the walk. Two-wire peripherals are placed as whole pairs. The SPI slave-select line takes a pin only in four-wire mode. The number of capture/compare outputs comes from a count field. An overflow flag reports that at least one enabled signal found no pin.

Top module: `pin_xbar_alloc`

## Requirements
- R1: Enabled signals are placed on available pins in ascending pin order (port 0 bit 0 first, port 3 bit 7 last), following this priority and code list: SCK=1, MISO=2, MOSI=3, NSS=4, SDA=5, SCL=6, CP0=7, CP0A=8, CP1=9, CP1A=10, SYSCLK=11, CEX0..CEX4=12..16, ECI=17, T0=18, T1=19, TX1=20, RX1=21. Each pin code is 5 bits wide, and pin p sits at bits [5p+4:5p] of `pin_code`.
- R2: A pin whose `skip_mask` bit is set reads code 31 and is never given a walked signal.
- R3: When `uart0_en` is set, pin 4 reads TX0 (code 22) and pin 5 reads RX0 (code 23). This holds even if those pins are skipped, and the walk passes over both pins.
- R4: SMBus (SDA/SCL) and UART1 (TX1/RX1) are placed only as complete pairs. If the first signal of a pair would land on the last available pin, it is dropped, and that pin becomes general-purpose I/O (code 0).
- R5: With `spi_en` set, NSS is placed only when `spi_four_wire` is 1. Otherwise only SCK, MISO and MOSI are walked.
- R6: `cex_count` = k places CEX0 up to CEX(k-1), starting from CEX0. Values above 5 place all five outputs.
- R7: UART1, enabled by one bit `uart1_en`, takes the two positions right after T1 in priority.
- R8: `overflow` is 1 exactly when the enabled walked signals outnumber the available pins. A signal without a pin is left unassigned.
- R9: Every available pin not used by the walk reads general-purpose I/O, code 0.
- R10: The configuration takes effect on the rising clock edge where `cfg_load` is 1, and input changes without `cfg_load` leave the outputs unchanged. Reset returns every pin to code 0 with `overflow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration inputs |
| spi_en | input | 1 | SPI group enable |
| spi_four_wire | input | 1 | 1 = four-wire SPI (NSS placed) |
| smb_en | input | 1 | SMBus pair enable |
| uart0_en | input | 1 | UART0 enable (fixed pins 4 and 5) |
| uart1_en | input | 1 | UART1 pair enable |
| cmp_en | input | 4 | Comparator output enables: bit0 CP0, bit1 CP0A, bit2 CP1, bit3 CP1A |
| sysclk_en | input | 1 | System clock output enable |
| cex_count | input | 3 | Number of capture/compare outputs |
| eci_en | input | 1 | External counter input enable |
| t0_en | input | 1 | Timer 0 input enable |
| t1_en | input | 1 | Timer 1 input enable |
| skip_mask | input | 32 | Per-pin skip bits, bit p = pin p |
| pin_code | output | 160 | 5-bit owner code per pin |
| overflow | output | 1 | An enabled signal found no pin |

## Verification
The walk is tried with single groups on a clean pin range, which shows that codes land in priority order. Leading skips shift every placement by the skipped count. The fixed UART0 pins, tried with and without their skip bits, show that placements bend around pins 4 and 5 and that the fixed pins win over the mask. Pin ranges cut to exactly fit, one short, and short by half a pair separate a plain overflow from a dropped pair head. Count values of 3 and 7 separate partial CEX placement from clamped placement.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int CODE_W   = 5;
  localparam int NUM_CAND = 21;
  localparam int CEX_MAX  = 5;

  localparam logic [CODE_W-1:0] CODE_GPIO = 5'd0;
  localparam logic [CODE_W-1:0] CODE_SKIP = 5'd31;
  localparam logic [CODE_W-1:0] CODE_TX0  = 5'd22;
  localparam logic [CODE_W-1:0] CODE_RX0  = 5'd23;

  localparam int TX0_PIN = 4;
  localparam int RX0_PIN = 5;

  // candidate slot numbers (code = slot + 1)
  localparam int SLOT_SDA  = 4;
  localparam int SLOT_CP0  = 6;
  localparam int SLOT_SYS  = 10;
  localparam int SLOT_CEX0 = 11;
  localparam int SLOT_ECI  = 16;
  localparam int SLOT_TX1  = 19;

  typedef struct packed {
    logic       spi_en;
    logic       spi_4w;
    logic       smb_en;
    logic       uart0_en;
    logic       uart1_en;
    logic [3:0] cmp_en;
    logic       sysclk_en;
    logic [2:0] cex_cnt;
    logic       eci_en;
    logic       t0_en;
    logic       t1_en;
  } xbar_cfg_t;
endpackage

// File: rtl/pxb_cfg_reg.sv
module pxb_cfg_reg
  import pxb_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  xbar_cfg_t       cfg_d,
  input  logic [NPIN-1:0] skip_d,
  output xbar_cfg_t       cfg_q,
  output logic [NPIN-1:0] skip_q
);
  xbar_cfg_t       cfg_nxt;
  logic [NPIN-1:0] skip_nxt;

  always_comb begin
    cfg_nxt  = cfg_q;
    skip_nxt = skip_q;
    if (load) begin
      cfg_nxt  = cfg_d;
      skip_nxt = skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      skip_q <= '0;
    end else begin
      cfg_q  <= cfg_nxt;
      skip_q <= skip_nxt;
    end
  end
endmodule

// File: rtl/pxb_req_list.sv
module pxb_req_list
  import pxb_pkg::*;
#(
  parameter int NCAND = NUM_CAND,
  localparam int IW = $clog2(NCAND),
  localparam int CW = $clog2(NCAND + 1)
) (
  input  xbar_cfg_t                cfg,
  output logic [NCAND-1:0][CODE_W-1:0] req_code,
  output logic [NCAND-1:0]         req_head,
  output logic [CW-1:0]            req_cnt
);
  logic [NCAND-1:0] cand_v;

  // which candidates are requested by the configuration
  always_comb begin
    cand_v = '0;
    cand_v[0] = cfg.spi_en;
    cand_v[1] = cfg.spi_en;
    cand_v[2] = cfg.spi_en;
    cand_v[3] = cfg.spi_en & cfg.spi_4w;
    cand_v[SLOT_SDA]     = cfg.smb_en;
    cand_v[SLOT_SDA + 1] = cfg.smb_en;
    for (int c = 0; c < 4; c++) begin
      cand_v[SLOT_CP0 + c] = cfg.cmp_en[c];
    end
    cand_v[SLOT_SYS] = cfg.sysclk_en;
    for (int j = 0; j < CEX_MAX; j++) begin
      cand_v[SLOT_CEX0 + j] = (int'(cfg.cex_cnt) > j);
    end
    cand_v[SLOT_ECI]     = cfg.eci_en;
    cand_v[SLOT_ECI + 1] = cfg.t0_en;
    cand_v[SLOT_ECI + 2] = cfg.t1_en;
    cand_v[SLOT_TX1]     = cfg.uart1_en;
    cand_v[SLOT_TX1 + 1] = cfg.uart1_en;
  end

  // compact requested candidates into priority order
  always_comb begin
    logic [CW-1:0] n;
    n        = '0;
    req_code = '0;
    req_head = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (cand_v[i]) begin
        req_code[IW'(n)] = CODE_W'(i + 1);
        req_head[IW'(n)] = (i == SLOT_SDA) || (i == SLOT_TX1);
        n = n + CW'(1);
      end
    end
    req_cnt = n;
  end
endmodule

// File: rtl/pxb_pin_walk.sv
module pxb_pin_walk
  import pxb_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int NCAND = NUM_CAND,
  localparam int IW = $clog2(NCAND),
  localparam int CW = $clog2(NCAND + 1),
  localparam int RW = $clog2(NPIN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN-1:0]            skip,
  input  logic                       uart0_en,
  input  logic [NCAND-1:0][CODE_W-1:0] req_code,
  input  logic [NCAND-1:0]           req_head,
  input  logic [CW-1:0]              req_cnt,
  output logic [NPIN-1:0][CODE_W-1:0] pin_code,
  output logic                       overflow
);
  logic [NPIN-1:0] fixed_pin;
  logic [NPIN-1:0] avail;
  logic [RW-1:0]   rank [NPIN+1];
  logic [RW-1:0]   need;
  logic [RW-1:0]   fit;
  logic [RW-1:0]   eff;

  // fixed and walkable pins
  always_comb begin
    fixed_pin = '0;
    fixed_pin[TX0_PIN] = uart0_en;
    fixed_pin[RX0_PIN] = uart0_en;
    avail = ~skip & ~fixed_pin;
  end

  // running count of walkable pins below each pin
  always_comb begin
    rank[0] = '0;
    for (int p = 0; p < NPIN; p++) begin
      rank[p+1] = rank[p] + RW'(avail[p]);
    end
  end

  // how many requested signals actually get a pin
  always_comb begin
    need     = RW'(req_cnt);
    overflow = need > rank[NPIN];
    fit      = overflow ? rank[NPIN] : need;
    eff      = fit;
    if (overflow && (fit != '0) && req_head[IW'(fit - RW'(1))]) begin
      eff = fit - RW'(1);
    end
  end

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      always_comb begin
        if (fixed_pin[p]) begin
          pin_code[p] = (p == TX0_PIN) ? CODE_TX0 : CODE_RX0;
        end else if (skip[p]) begin
          pin_code[p] = CODE_SKIP;
        end else if (rank[p] < eff) begin
          pin_code[p] = req_code[IW'(rank[p])];
        end else begin
          pin_code[p] = CODE_GPIO;
        end
      end

      // R2
      skip_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip[p] && !(uart0_en && (p == TX0_PIN || p == RX0_PIN)))
          |-> (pin_code[p] == CODE_SKIP));
    end
  endgenerate

  // signals placed, counted from the pin outputs
  logic [RW-1:0] placed_cnt;
  always_comb begin
    placed_cnt = '0;
    for (int p = 0; p < NPIN; p++) begin
      if ((pin_code[p] != CODE_GPIO) && (int'(pin_code[p]) <= NCAND)) begin
        placed_cnt = placed_cnt + RW'(1);
      end
    end
  end

  // R3
  fixed_uart0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart0_en |-> (pin_code[TX0_PIN] == CODE_TX0 && pin_code[RX0_PIN] == CODE_RX0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> (placed_cnt == RW'(req_cnt)));
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pxb_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_WIDTH = 8,
  localparam int NPIN = NUM_PORTS * PORT_WIDTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic                   spi_en,
  input  logic                   spi_four_wire,
  input  logic                   smb_en,
  input  logic                   uart0_en,
  input  logic                   uart1_en,
  input  logic [3:0]             cmp_en,
  input  logic                   sysclk_en,
  input  logic [2:0]             cex_count,
  input  logic                   eci_en,
  input  logic                   t0_en,
  input  logic                   t1_en,
  input  logic [NPIN-1:0]        skip_mask,
  output logic [NPIN*CODE_W-1:0] pin_code,
  output logic                   overflow
);
  localparam int CW = $clog2(NUM_CAND + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xbar_cfg_t cfg_d;
  xbar_cfg_t cfg_q;
  logic [NPIN-1:0] skip_q;

  always_comb begin
    cfg_d.spi_en    = spi_en;
    cfg_d.spi_4w    = spi_four_wire;
    cfg_d.smb_en    = smb_en;
    cfg_d.uart0_en  = uart0_en;
    cfg_d.uart1_en  = uart1_en;
    cfg_d.cmp_en    = cmp_en;
    cfg_d.sysclk_en = sysclk_en;
    cfg_d.cex_cnt   = cex_count;
    cfg_d.eci_en    = eci_en;
    cfg_d.t0_en     = t0_en;
    cfg_d.t1_en     = t1_en;
  end

  pxb_cfg_reg #(.NPIN(NPIN)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (cfg_load),
    .cfg_d  (cfg_d),
    .skip_d (skip_mask),
    .cfg_q  (cfg_q),
    .skip_q (skip_q)
  );

  logic [NUM_CAND-1:0][CODE_W-1:0] req_code;
  logic [NUM_CAND-1:0]             req_head;
  logic [CW-1:0]                   req_cnt;

  pxb_req_list #(.NCAND(NUM_CAND)) u_req (
    .cfg      (cfg_q),
    .req_code (req_code),
    .req_head (req_head),
    .req_cnt  (req_cnt)
  );

  logic [NPIN-1:0][CODE_W-1:0] pin_arr;

  pxb_pin_walk #(.NPIN(NPIN), .NCAND(NUM_CAND)) u_walk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .skip     (skip_q),
    .uart0_en (cfg_q.uart0_en),
    .req_code (req_code),
    .req_head (req_head),
    .req_cnt  (req_cnt),
    .pin_code (pin_arr),
    .overflow (overflow)
  );

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_out
      assign pin_code[p*CODE_W +: CODE_W] = pin_arr[p];
    end
  endgenerate

  // presence flags for assertions
  logic nss_seen;
  logic cex0_seen;
  always_comb begin
    nss_seen  = 1'b0;
    cex0_seen = 1'b0;
    for (int p = 0; p < NPIN; p++) begin
      if (pin_arr[p] == CODE_W'(4))  nss_seen  = 1'b1;
      if (pin_arr[p] == CODE_W'(12)) cex0_seen = 1'b1;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_load |=> $stable(pin_code));

  // R5
  spi_three_wire_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_q.spi_4w |-> !nss_seen);

  // R6
  cex_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_q.cex_cnt == 3'd0) |-> !cex0_seen);
endmodule

// File: tb/pin_xbar_alloc_bench.sv
`timescale 1ns/1ps
module pin_xbar_alloc_bench;
  localparam int NPIN = 32;
  localparam int NVEC = 13;

  typedef struct packed {
    logic        spi;
    logic        w4;
    logic        smb;
    logic        u0;
    logic        u1;
    logic [3:0]  cmp;
    logic        sys;
    logic [2:0]  cex;
    logic        eci;
    logic        t0;
    logic        t1;
    logic [31:0] skip;
    logic        ovf;
    logic [4:0]  ppin;
    logic [4:0]  pcode;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,5'd3,5'd4},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,5'd3,5'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'h0000_0003,1'b0,5'd5,5'd4},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,4'hF,1'b0,3'd0,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,5'd6,5'd5},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,3'd3,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,5'd3,5'd14},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,3'd7,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,5'd4,5'd16},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,1'b0,3'd0,1'b1,1'b0,1'b1,32'h0000_0000,1'b0,5'd3,5'd21},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'hFFFF_FFF0,1'b1,5'd3,5'd4},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'hFFFF_FFF0,1'b1,5'd3,5'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'hFFFF_FFFF,1'b1,5'd31,5'd31},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'h0000_0030,1'b0,5'd4,5'd22},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,32'hFFFF_FFFC,1'b0,5'd1,5'd6},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h0,1'b0,3'd0,1'b1,1'b0,1'b1,32'hFFFF_FFF8,1'b1,5'd2,5'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:  return "R1/R9";
      1:  return "R5";
      2:  return "R2";
      3:  return "R3";
      4:  return "R6";
      5:  return "R6";
      6:  return "R7";
      7:  return "R8";
      8:  return "R4";
      9:  return "R2";
      10: return "R3";
      11: return "R8";
      default: return "R4";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load, spi_en, spi_four_wire, smb_en, uart0_en, uart1_en;
  logic [3:0] cmp_en;
  logic sysclk_en;
  logic [2:0] cex_count;
  logic eci_en, t0_en, t1_en;
  logic [NPIN-1:0] skip_mask;
  logic [NPIN*5-1:0] pin_code;
  logic overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_xbar_alloc u_pin_xbar_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .spi_en(spi_en), .spi_four_wire(spi_four_wire), .smb_en(smb_en),
    .uart0_en(uart0_en), .uart1_en(uart1_en), .cmp_en(cmp_en),
    .sysclk_en(sysclk_en), .cex_count(cex_count), .eci_en(eci_en),
    .t0_en(t0_en), .t1_en(t1_en), .skip_mask(skip_mask),
    .pin_code(pin_code), .overflow(overflow)
  );

  // independent pin-by-pin reference walk
  function automatic void model(input vec_t v, output logic [NPIN*5-1:0] codes,
                                output logic ovf);
    int lst [24];
    int n = 0;
    int ptr = 0;
    int last_pin = 0;
    if (v.spi) begin
      lst[n] = 1; n++; lst[n] = 2; n++; lst[n] = 3; n++;
      if (v.w4) begin lst[n] = 4; n++; end
    end
    if (v.smb) begin lst[n] = 5; n++; lst[n] = 6; n++; end
    for (int c = 0; c < 4; c++) if (v.cmp[c]) begin lst[n] = 7 + c; n++; end
    if (v.sys) begin lst[n] = 11; n++; end
    for (int j = 0; j < 5; j++) if (j < int'(v.cex)) begin lst[n] = 12 + j; n++; end
    if (v.eci) begin lst[n] = 17; n++; end
    if (v.t0)  begin lst[n] = 18; n++; end
    if (v.t1)  begin lst[n] = 19; n++; end
    if (v.u1)  begin lst[n] = 20; n++; lst[n] = 21; n++; end
    codes = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (v.u0 && p == 4)      codes[p*5 +: 5] = 5'd22;
      else if (v.u0 && p == 5) codes[p*5 +: 5] = 5'd23;
      else if (v.skip[p])      codes[p*5 +: 5] = 5'd31;
      else if (ptr < n) begin
        codes[p*5 +: 5] = 5'(lst[ptr]);
        last_pin = p;
        ptr++;
      end
    end
    ovf = (ptr < n);
    if (ovf && ptr > 0 && (lst[ptr-1] == 5 || lst[ptr-1] == 20))
      codes[last_pin*5 +: 5] = 5'd0;
  endfunction

  task automatic drive(input vec_t v, input logic load);
    spi_en = v.spi; spi_four_wire = v.w4; smb_en = v.smb;
    uart0_en = v.u0; uart1_en = v.u1; cmp_en = v.cmp;
    sysclk_en = v.sys; cex_count = v.cex; eci_en = v.eci;
    t0_en = v.t0; t1_en = v.t1; skip_mask = v.skip;
    cfg_load = load;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    drive(v, 1'b1);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic check_bus(input string req, input logic [NPIN*5-1:0] exp_codes,
                           input logic exp_ovf);
    checks++;
    if (pin_code !== exp_codes || overflow !== exp_ovf) begin
      fails++;
      $display("FAIL %s: codes=%h ovf=%b expected codes=%h ovf=%b",
               req, pin_code, overflow, exp_codes, exp_ovf);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10: watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [NPIN*5-1:0] exp_codes;
    logic exp_ovf;
    vec_t hold_v;
    rst_n = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check_bus("R10 reset", '0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bus("R10 after release", '0, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      model(VECS[i], exp_codes, exp_ovf);
      check_bus(tag_of(i), exp_codes, exp_ovf);
      checks++;
      if (pin_code[VECS[i].ppin*5 +: 5] !== VECS[i].pcode || overflow !== VECS[i].ovf) begin
        fails++;
        $display("FAIL %s probe pin %0d: code=%0d ovf=%b expected code=%0d ovf=%b",
                 tag_of(i), VECS[i].ppin, pin_code[VECS[i].ppin*5 +: 5], overflow,
                 VECS[i].pcode, VECS[i].ovf);
      end
    end

    // R10: inputs change without load, outputs hold
    hold_v = VECS[0];
    apply(hold_v);
    model(hold_v, exp_codes, exp_ovf);
    @(negedge clk);
    drive(VECS[9], 1'b0);
    repeat (3) @(negedge clk);
    check_bus("R10 no load", exp_codes, exp_ovf);

    // R10: load now takes it
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    model(VECS[9], exp_codes, exp_ovf);
    check_bus("R10 load", exp_codes, exp_ovf);

    // R10: reset in mid-run clears everything
    rst_n = 1'b0;
    #1;
    check_bus("R10 async reset", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bus("R10 reset held", '0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule